// File: doc/BRIEF.md
# Erase-free unary minute logger

This block keeps a tally of elapsed minutes in a region of flash that is never erased. Each minute is recorded by programming one more flash bit from 1 to 0, so the stored record is a thermometer code that only grows. The count lives in a register for fast use. It is written to flash through a byte-wide port with address, write data, write strobe, registered read data and a busy flag.

After reset the block walks the region from the lowest byte upward and rebuilds the count from the bits that are already programmed. It raises `ready` once the scan is done. After that, each single-cycle `tick` from an external minute timebase adds one programmed bit. When the region is completely programmed, the block reports `full` and ignores further ticks. A tick that arrives while the port is occupied is kept and is serviced as soon as the port is free.

Top module: `unary_minute_log`

## Requirements
- R1: The record holds CAPACITY bits (default 4320) in CAPACITY/8 consecutive bytes starting at address 0. An erased byte reads 8'hFF. Minute number n (counting from 0) is bit n%8 of byte n/8, and a programmed bit reads 0.
- R2: With `ready` high and count N below CAPACITY, a tick makes the block pulse `flash_we` for one cycle. The pulse carries address N/8 and data 8'hFF shifted left by (N%8)+1. Bit N%8 and every lower bit of that byte are therefore 0, and all higher bits are 1. The count then becomes N+1.
- R3: `flash_we` is high for single cycles only and is never raised while `flash_busy` is high. Each serviced tick produces exactly one write.
- R4: A tick that arrives while a write is in progress (busy high) or while the rebuild scan runs is held and later serviced. It then produces the same write and the same increment as a tick on an idle port.
- R5: After reset, the block reads bytes upward from address 0 and adds 8 for each 8'h00 byte. At the first byte that is not 8'h00 it adds the number of zero bits in that byte and stops. If every byte is 8'h00 the count is CAPACITY. The rebuilt count appears together with the rise of `ready`.
- R6: `full` is high exactly when the count equals CAPACITY.
- R7: While `full` is high, ticks cause no flash write and the count stays at CAPACITY.
- R8: During reset and the rebuild scan, `ready` is low and `flash_we` stays low.
- R9: While `ready` is high, the count never decreases and rises by at most 1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the rebuild scan |
| tick | input | 1 | Single-cycle minute pulse |
| flash_addr | output | ADDR_W (10) | Byte address to the flash port |
| flash_wdata | output | 8 | Byte pattern to program (zeros program bits) |
| flash_we | output | 1 | Single-cycle write strobe |
| flash_rdata | input | 8 | Read data, valid one cycle after the address |
| flash_busy | input | 1 | Flash is programming; no strobe is accepted |
| count | output | CNT_W (13) | Elapsed minutes, valid while ready is high |
| full | output | 1 | All bits of the record are programmed |
| ready | output | 1 | Rebuild scan has finished |

## Verification
Ticks are applied on a blank region, across a byte boundary, back to back while the flash is busy, and during the rebuild scan. These patterns separate the byte and bit arithmetic from the pending-tick handling. The scan is given a blank region, a region with whole zero bytes followed by a partly cleared byte, a region one bit short of full, and a fully programmed region. Together they distinguish the 8-per-byte sum, the partial-byte bit count, the stopping rule and the saturated end case. Writes are counted at the model flash port, which shows whether an ignored tick at saturation still reaches the flash.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

  // Pattern that programs bit k and every bit below it.
  function automatic logic [7:0] prog_pattern(input logic [2:0] k);
    logic [7:0] p;
    p = 8'hFF << (k + 3'd1);
    if (k == 3'd7) p = 8'h00;
    return p;
  endfunction

  function automatic logic [3:0] zero_bits(input logic [7:0] b);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) begin
      if (!b[i]) n = n + 4'd1;
    end
    return n;
  endfunction

  typedef enum logic [1:0] {
    SC_REQ  = 2'd0,
    SC_WAIT = 2'd1,
    SC_EVAL = 2'd2,
    SC_DONE = 2'd3
  } scan_state_t;

endpackage

// File: rtl/ulog_scan.sv
module ulog_scan
  import ulog_pkg::*;
#(
  parameter int NBYTES = 540,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NBYTES - 1);

  scan_state_t      st;
  logic [CNT_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SC_REQ;
      rd_addr  <= '0;
      acc      <= '0;
      load     <= 1'b0;
      load_val <= '0;
    end else begin
      load <= 1'b0;
      unique case (st)
        SC_REQ:  if (!busy) st <= SC_WAIT;
        SC_WAIT: st <= SC_EVAL;
        SC_EVAL: begin
          if (rdata == 8'h00) begin
            if (rd_addr == LAST) begin
              load_val <= acc + CNT_W'(8);
              load     <= 1'b1;
              st       <= SC_DONE;
            end else begin
              acc     <= acc + CNT_W'(8);
              rd_addr <= rd_addr + 1'b1;
              st      <= SC_REQ;
            end
          end else begin
            load_val <= acc + CNT_W'(zero_bits(rdata));
            load     <= 1'b1;
            st       <= SC_DONE;
          end
        end
        default: st <= SC_DONE;
      endcase
    end
  end

  // R5: a result is delivered only once per scan
  p_single_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

endmodule

// File: rtl/ulog_writer.sv
module ulog_writer
  import ulog_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ready,
  input  logic              full,
  input  logic              busy,
  input  logic [CNT_W-1:0]  count,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              issue
);

  logic pend;

  always_comb begin
    issue = ready && !full && !busy && !we && (tick || pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      we    <= 1'b0;
      waddr <= '0;
      wdata <= 8'hFF;
    end else begin
      we <= issue;
      if (issue) begin
        waddr <= ADDR_W'(count >> 3);
        wdata <= prog_pattern(count[2:0]);
        pend  <= 1'b0;
      end else if (full) begin
        pend <= 1'b0;
      end else if (tick) begin
        pend <= 1'b1;
      end
    end
  end

  // R3: the write strobe lasts one cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  // R2: every programmed pattern clears the lowest bit of its byte
  p_low_bit_cleared_r2: assert property (@(posedge clk) disable iff (rst)
    we |-> (wdata[0] == 1'b0));

endmodule

// File: rtl/unary_minute_log.sv
module unary_minute_log
  import ulog_pkg::*;
#(
  parameter int CAPACITY = 4320,
  localparam int NBYTES  = CAPACITY / 8,
  localparam int ADDR_W  = $clog2(NBYTES),
  localparam int CNT_W   = $clog2(CAPACITY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_wdata,
  output logic              flash_we,
  input  logic [7:0]        flash_rdata,
  input  logic              flash_busy,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              ready
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(CAPACITY);

  logic [ADDR_W-1:0] scan_addr, wr_addr;
  logic              scan_load, issue;
  logic [CNT_W-1:0]  scan_val, count_next;

  ulog_scan #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst(rst), .busy(flash_busy), .rdata(flash_rdata),
    .rd_addr(scan_addr), .load(scan_load), .load_val(scan_val)
  );

  ulog_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .tick(tick), .ready(ready), .full(full),
    .busy(flash_busy), .count(count), .we(flash_we), .waddr(wr_addr),
    .wdata(flash_wdata), .issue(issue)
  );

  always_comb begin
    count_next = count;
    if (scan_load)  count_next = scan_val;
    else if (issue) count_next = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      ready <= 1'b0;
    end else begin
      count <= count_next;
      full  <= (count_next == CAP);
      if (scan_load) ready <= 1'b1;
    end
  end

  assign flash_addr = ready ? wr_addr : scan_addr;

  // R8: no programming before the rebuild has finished
  p_no_write_in_scan_r8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !flash_we);

  // R6: the record at capacity is reported full
  p_full_at_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && count == CAP) |-> full);

  // R7: a saturated counter issues no further writes
  p_sat_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (full && $past(full)) |-> !flash_we);

  // R9: monotonic single steps once running
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |->
      (count == $past(count) || count == $past(count) + 1'b1));

  // R3: strobe only toward an idle flash
  p_we_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we) |-> $past(!flash_busy));

endmodule

// File: tb/tb_unary_minute_log.sv
`timescale 1ns/1ps
module tb_unary_minute_log;

  localparam int CAP = 4320;
  localparam int NB  = CAP / 8;
  localparam int BUSY_CYC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [9:0]  flash_addr;
  logic [7:0]  flash_wdata;
  logic        flash_we;
  logic [7:0]  flash_rdata;
  logic        flash_busy;
  logic [12:0] count;
  logic        full, ready;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  unary_minute_log dut (
    .clk(clk), .rst(rst), .tick(tick), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_we(flash_we), .flash_rdata(flash_rdata),
    .flash_busy(flash_busy), .count(count), .full(full), .ready(ready)
  );

  // flash model: AND-programming, registered read, busy after each write
  logic [7:0] mem [NB];
  int         busy_cnt = 0;
  int         writes = 0;
  logic       do_load = 1'b0;
  int         ld_zero = 0;
  logic [7:0] ld_tail = 8'hFF;

  assign flash_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    flash_rdata <= (int'(flash_addr) < NB) ? mem[flash_addr] : 8'hFF;
    if (do_load) begin
      for (int i = 0; i < NB; i++)
        mem[i] <= (i < ld_zero) ? 8'h00 : ((i == ld_zero) ? ld_tail : 8'hFF);
      busy_cnt <= 0;
    end else if (flash_we && busy_cnt == 0) begin
      if (int'(flash_addr) < NB) mem[flash_addr] <= mem[flash_addr] & flash_wdata;
      busy_cnt <= BUSY_CYC;
      writes <= writes + 1;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input int zeros, input logic [7:0] tail, input bit load);
    @(negedge clk);
    rst = 1'b1;
    if (load) begin
      ld_zero = zeros; ld_tail = tail; do_load = 1'b1;
      @(negedge clk);
      do_load = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic settle();
    repeat (BUSY_CYC + 8) @(negedge clk);
  endtask

  task automatic t_blank_reset();
    restart(0, 8'hFF, 1'b1);
    @(negedge clk);
    check("R8 ready low in scan", int'(ready), 0);
    check("R8 no strobe in scan", int'(flash_we), 0);
    wait_ready();
    check("R5 blank rebuild count", int'(count), 0);
    check("R6 blank not full", int'(full), 0);
  endtask

  task automatic t_first_ticks();
    pulse_tick(); settle();
    check("R2 first pattern", int'(mem[0]), 8'hFE);
    check("R2 count after one", int'(count), 1);
    for (int i = 0; i < 8; i++) begin
      pulse_tick(); settle();
    end
    check("R2 byte0 all programmed", int'(mem[0]), 8'h00);
    check("R1 byte1 bit0", int'(mem[1]), 8'hFE);
    check("R2 count nine", int'(count), 9);
  endtask

  task automatic t_pending_busy();
    int w0;
    w0 = writes;
    pulse_tick();
    repeat (2) @(negedge clk);
    check("R4 busy during write", int'(flash_busy), 1);
    pulse_tick();
    settle(); settle();
    check("R3 two writes", writes - w0, 2);
    check("R4 held tick counted", int'(count), 11);
    check("R4 held tick pattern", int'(mem[1]), 8'hF8);
  endtask

  task automatic t_rebuild_same();
    restart(0, 8'hFF, 1'b0);
    wait_ready();
    check("R5 rebuild after ticks", int'(count), 11);
  endtask

  task automatic t_partial();
    restart(100, 8'hF8, 1'b1);
    wait_ready();
    check("R5 partial rebuild", int'(count), 803);
    pulse_tick(); settle();
    check("R2 continues partial byte", int'(mem[100]), 8'hF0);
    check("R2 count 804", int'(count), 804);
  endtask

  task automatic t_saturate();
    int w0;
    restart(NB - 1, 8'h80, 1'b1);
    wait_ready();
    check("R5 one short", int'(count), CAP - 1);
    check("R6 not yet full", int'(full), 0);
    pulse_tick(); settle();
    check("R2 last byte", int'(mem[NB-1]), 8'h00);
    check("R6 full at cap", int'(full), 1);
    check("R6 count cap", int'(count), CAP);
    w0 = writes;
    pulse_tick(); settle();
    pulse_tick(); settle();
    check("R7 no write when full", writes - w0, 0);
    check("R7 count held", int'(count), CAP);
  endtask

  task automatic t_full_rebuild();
    restart(0, 8'hFF, 1'b0);
    wait_ready();
    check("R5 all-zero rebuild", int'(count), CAP);
    check("R6 full after rebuild", int'(full), 1);
  endtask

  task automatic t_tick_in_scan();
    restart(0, 8'hFF, 1'b1);
    pulse_tick();
    check("R4 tick seen during scan", int'(ready), 0);
    wait_ready();
    settle();
    check("R4 scan-time tick counted", int'(count), 1);
    check("R4 scan-time tick written", int'(mem[0]), 8'hFE);
  endtask

  initial begin
    fork
      begin
        t_blank_reset();
        t_first_ticks();
        t_pending_busy();
        t_rebuild_same();
        t_partial();
        t_saturate();
        t_full_rebuild();
        t_tick_in_scan();
      end
      begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule